// File: doc/BRIEF.md
# Ring Index and Watermark Controller

This block keeps the producer and consumer positions of the two descriptor rings that belong to one copy channel: a source ring of queued transmit descriptors and a destination ring of posted receive buffers. Software moves the write index of either ring through a small configuration write port. The datapath moves the matching read index one step with a single-cycle completion pulse. Both read indices and both ring levels are always visible on output ports for polling.

Ring sizes are a power of two. All index arithmetic wraps through a mask, and the level of a ring is the wrapped difference of its write and read indices. Each ring has a programmable low and high threshold. Crossing either threshold, finishing a copy, overrunning a ring and datapath error pulses all set sticky status bits. Software clears those bits by writing ones. An interrupt line merges the status bits that software has enabled. A halt command freezes both rings once the descriptor in flight has finished, and the block acknowledges the halt on a status output.

Top module: `ring_idx_ctrl`

## Requirements
- R1: Each accepted completion pulse moves that ring's read index up by one, modulo 2^IDX_W. The level output always equals (write index − read index) mod 2^IDX_W.
- R2: A write to the source write index (address 0) is accepted only when (new − current write index) mod 2^IDX_W does not exceed 2^IDX_W − 1 − level. A write that fails this test leaves the index unchanged and sets status bit 5. The same test applies to the destination write index (address 1), which sets bit 6 when it fails.
- R3: A completion pulse on a ring whose level is 0 is ignored and leaves the read index unchanged. On the destination ring such a pulse also sets status bit 6.
- R4: Each accepted source completion pulse sets status bit 0, which marks a finished copy.
- R5: A threshold word (address 2 for source, 3 for destination) holds the low threshold in bits [31:16] and the high threshold in bits [15:0]. Both thresholds reset to 0. A high event is a level that rises from at most the high threshold to above it. A low event is a level that falls from at least the low threshold to below it. The events set bit 1 (source high), bit 2 (source low), bit 3 (destination high) and bit 4 (destination low), one cycle after the index change that caused them.
- R6: Datapath error pulses err_in[0..3] set status bits 7 to 10 respectively: destination length violation, source length error, destination address error and bus error.
- R7: Status bits stay set until software writes a 1 to that bit position at address 5. When a set and a clear of the same bit fall in one cycle, the bit stays set.
- R8: irq equals the OR of status ANDed with the enable mask written at address 4. Bit n of the mask enables status bit n.
- R9: Writing bit 0 at address 6 requests a halt. halted rises on the edge after xfer_busy is low while the request is held. While halted is high, completion pulses change no index. Writing 0 withdraws the request, and halted falls one cycle later.
- R10: After reset, indices, levels, status, enables, irq and halted are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| src_done | input | 1 | Source descriptor consumed by datapath |
| dst_done | input | 1 | Destination buffer filled by datapath |
| err_in | input | 4 | Datapath error pulses |
| xfer_busy | input | 1 | A descriptor is in flight |
| src_rd_idx | output | IDX_W | Source read index |
| dst_rd_idx | output | IDX_W | Destination read index |
| src_level | output | IDX_W | Source entries queued |
| dst_level | output | IDX_W | Destination buffers posted |
| status | output | 11 | Sticky status bits |
| irq | output | 1 | Enabled status summary |
| halted | output | 1 | Halt acknowledge |

## Verification
The collision that matters most is an event that sets a status bit arriving in the same cycle as a software write-1 clear of that bit. The bench raises a datapath error pulse on the same edge as a clear write to its bit, and the bit must remain set. A second collision is a completion pulse that arrives while halted is high. The bench judges it from the read index and the level, which must not move.

// File: rtl/ring_idx_pkg.sv
package ring_idx_pkg;
  typedef enum logic [2:0] {
    A_SRC_WR   = 3'd0,
    A_DST_WR   = 3'd1,
    A_SRC_WM   = 3'd2,
    A_DST_WM   = 3'd3,
    A_IRQ_EN   = 3'd4,
    A_STAT_CLR = 3'd5,
    A_CMD      = 3'd6
  } reg_addr_e;

  localparam int STAT_W   = 11;
  localparam int TH_W     = 16;
  localparam int B_DONE   = 0;
  localparam int B_SRC_HI = 1;
  localparam int B_SRC_LO = 2;
  localparam int B_DST_HI = 3;
  localparam int B_DST_LO = 4;
  localparam int B_SRC_OV = 5;
  localparam int B_DST_OV = 6;
  localparam int B_ERR0   = 7;
endpackage

// File: rtl/ring_side.sv
module ring_side #(
  parameter int IDX_W = 4,
  parameter int TH_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_we,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic             adv,
  input  logic             halt,
  input  logic [TH_W-1:0]  lo_th,
  input  logic [TH_W-1:0]  hi_th,
  output logic [IDX_W-1:0] rd_idx,
  output logic [IDX_W-1:0] occ,
  output logic             wr_reject,
  output logic             adv_reject,
  output logic             adv_ok,
  output logic             hi_evt,
  output logic             lo_evt
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] MAX_OCC = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] wr_q, rd_q, occ_q, free_n, step;
  logic [TH_W-1:0]  occ_x, occp_x;
  logic             wr_ok;

  assign occ    = wr_q - rd_q;
  assign free_n = MAX_OCC - occ;
  assign step   = sw_idx - wr_q;
  assign wr_ok  = sw_we && (step <= free_n);
  assign wr_reject  = sw_we && !wr_ok;
  assign adv_ok     = adv && !halt && (occ != '0);
  assign adv_reject = adv && !halt && (occ == '0);
  assign rd_idx = rd_q;

  assign occ_x  = TH_W'(occ);
  assign occp_x = TH_W'(occ_q);
  assign hi_evt = (occ_x > hi_th) && (occp_x <= hi_th);
  assign lo_evt = (occ_x < lo_th) && (occp_x >= lo_th);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      occ_q <= '0;
    end else begin
      if (wr_ok)  wr_q <= sw_idx;
      if (adv_ok) rd_q <= rd_q + 1'b1;
      occ_q <= occ;
    end
  end

  // R1
  rd_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_q) |-> (rd_q == IDX_W'($past(rd_q) + 1'b1)));
  // R2
  reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wr_reject |=> $stable(wr_q));
  // R3
  empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && occ == '0) |=> $stable(rd_q));
  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halt |=> $stable(rd_q));
endmodule

// File: rtl/ring_status.sv
module ring_status #(
  parameter int STAT_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              clr_we,
  input  logic [STAT_W-1:0] clr_mask,
  input  logic [STAT_W-1:0] en,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic [STAT_W-1:0] st_q, st_d, clr_eff;

  assign clr_eff = clr_we ? clr_mask : '0;
  assign st_d    = (st_q & ~clr_eff) | set_vec;

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= st_d;
  end

  assign status = st_q;
  assign irq    = |(st_q & en);

  // R7
  set_win_chk: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));
  // R7
  clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_we && ((clr_mask & ~set_vec) != '0)) |=>
      ((status & $past(clr_mask & ~set_vec)) == '0));
endmodule

// File: rtl/ring_idx_ctrl.sv
module ring_idx_ctrl
  import ring_idx_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              src_done,
  input  logic              dst_done,
  input  logic [3:0]        err_in,
  input  logic              xfer_busy,
  output logic [IDX_W-1:0]  src_rd_idx,
  output logic [IDX_W-1:0]  dst_rd_idx,
  output logic [IDX_W-1:0]  src_level,
  output logic [IDX_W-1:0]  dst_level,
  output logic [STAT_W-1:0] status,
  output logic              irq,
  output logic              halted
);
  logic [2*TH_W-1:0] src_wm_q, dst_wm_q;
  logic [STAT_W-1:0] en_q, set_vec;
  logic              halt_req_q, halted_q;
  logic              src_we, dst_we, clr_we;
  logic              s_wrej, s_empty_unused, s_adv, s_hi, s_lo;
  logic              d_wrej, d_arej, d_adv_unused, d_hi, d_lo;

  assign src_we = cfg_we && (cfg_addr == A_SRC_WR);
  assign dst_we = cfg_we && (cfg_addr == A_DST_WR);
  assign clr_we = cfg_we && (cfg_addr == A_STAT_CLR);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_wm_q   <= '0;
      dst_wm_q   <= '0;
      en_q       <= '0;
      halt_req_q <= 1'b0;
      halted_q   <= 1'b0;
    end else begin
      if (cfg_we && cfg_addr == A_SRC_WM) src_wm_q <= cfg_wdata;
      if (cfg_we && cfg_addr == A_DST_WM) dst_wm_q <= cfg_wdata;
      if (cfg_we && cfg_addr == A_IRQ_EN) en_q <= cfg_wdata[STAT_W-1:0];
      if (cfg_we && cfg_addr == A_CMD)    halt_req_q <= cfg_wdata[0];
      halted_q <= halt_req_q && (halted_q || !xfer_busy);
    end
  end

  ring_side #(.IDX_W(IDX_W), .TH_W(TH_W)) u_src (
    .clk(clk), .rst(rst), .sw_we(src_we), .sw_idx(cfg_wdata[IDX_W-1:0]),
    .adv(src_done), .halt(halted_q),
    .lo_th(src_wm_q[2*TH_W-1:TH_W]), .hi_th(src_wm_q[TH_W-1:0]),
    .rd_idx(src_rd_idx), .occ(src_level), .wr_reject(s_wrej),
    .adv_reject(s_empty_unused), .adv_ok(s_adv), .hi_evt(s_hi), .lo_evt(s_lo)
  );

  ring_side #(.IDX_W(IDX_W), .TH_W(TH_W)) u_dst (
    .clk(clk), .rst(rst), .sw_we(dst_we), .sw_idx(cfg_wdata[IDX_W-1:0]),
    .adv(dst_done), .halt(halted_q),
    .lo_th(dst_wm_q[2*TH_W-1:TH_W]), .hi_th(dst_wm_q[TH_W-1:0]),
    .rd_idx(dst_rd_idx), .occ(dst_level), .wr_reject(d_wrej),
    .adv_reject(d_arej), .adv_ok(d_adv_unused), .hi_evt(d_hi), .lo_evt(d_lo)
  );

  always_comb begin
    set_vec = '0;
    set_vec[B_DONE]   = s_adv;
    set_vec[B_SRC_HI] = s_hi;
    set_vec[B_SRC_LO] = s_lo;
    set_vec[B_DST_HI] = d_hi;
    set_vec[B_DST_LO] = d_lo;
    set_vec[B_SRC_OV] = s_wrej;
    set_vec[B_DST_OV] = d_wrej | d_arej;
    set_vec[B_ERR0+3:B_ERR0] = err_in;
  end

  ring_status #(.STAT_W(STAT_W)) u_stat (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_we(clr_we),
    .clr_mask(cfg_wdata[STAT_W-1:0]), .en(en_q), .status(status), .irq(irq)
  );

  assign halted = halted_q;

  // R9
  halt_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(halted_q) |-> $past(halt_req_q && !xfer_busy));
  // R9
  halt_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (!halt_req_q) |=> !halted_q);
endmodule

// File: tb/ring_idx_ctrl_test.sv
module ring_idx_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic src_done = 1'b0, dst_done = 1'b0, xfer_busy = 1'b0;
  logic [3:0] err_in = '0;
  logic [W-1:0] src_rd_idx, dst_rd_idx, src_level, dst_level;
  logic [10:0] status;
  logic irq, halted;
  int checks = 0, fails = 0;

  // {write index, src_done pulses, expected read index, expected level}
  localparam logic [15:0] VEC [6] = '{
    {4'd5,  4'd2,  4'd2,  4'd3},
    {4'd9,  4'd4,  4'd6,  4'd3},
    {4'd15, 4'd0,  4'd6,  4'd9},
    {4'd3,  4'd7,  4'd13, 4'd6},
    {4'd12, 4'd10, 4'd7,  4'd5},
    {4'd0,  4'd9,  4'd0,  4'd0}
  };

  ring_idx_ctrl #(.IDX_W(W)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .src_done(src_done), .dst_done(dst_done),
    .err_in(err_in), .xfer_busy(xfer_busy), .src_rd_idx(src_rd_idx),
    .dst_rd_idx(dst_rd_idx), .src_level(src_level), .dst_level(dst_level),
    .status(status), .irq(irq), .halted(halted)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_src(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); src_done = 1'b1;
      @(negedge clk); src_done = 1'b0;
    end
  endtask

  task automatic pulse_dst(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); dst_done = 1'b1;
      @(negedge clk); dst_done = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R10 reset state
    chk("R10 src_rd", 32'(src_rd_idx), 0);
    chk("R10 levels", 32'({src_level, dst_level}), 0);
    chk("R10 status", 32'(status), 0);
    chk("R10 irq/halted", 32'({irq, halted}), 0);

    // R1 table walk with wrap-around
    foreach (VEC[k]) begin
      wr(3'd0, 32'(VEC[k][15:12]));
      pulse_src(int'(VEC[k][11:8]));
      chk($sformatf("R1 rd step %0d", k), 32'(src_rd_idx), 32'(VEC[k][7:4]));
      chk($sformatf("R1 level step %0d", k), 32'(src_level), 32'(VEC[k][3:0]));
    end
    // R4 copy complete
    idle(1);
    chk("R4 done bit", 32'(status[0]), 1);
    wr(3'd5, 32'h7FF);
    idle(1);
    chk("R7 clear all", 32'(status), 0);

    // R2 source overflow
    wr(3'd0, 32'd15);
    chk("R2 fill accepted", 32'(src_level), 15);
    wr(3'd0, 32'd0);
    idle(1);
    chk("R2 reject level", 32'(src_level), 15);
    chk("R2 overflow bit5", 32'(status[5]), 1);
    pulse_src(15);
    chk("R1 drained rd", 32'(src_rd_idx), 15);
    // R3 empty source pulse ignored
    pulse_src(1);
    chk("R3 src empty rd", 32'(src_rd_idx), 15);
    chk("R3 src empty level", 32'(src_level), 0);

    // R3 destination pulse with nothing posted
    wr(3'd5, 32'h7FF);
    pulse_dst(1);
    idle(1);
    chk("R3 dst rd hold", 32'(dst_rd_idx), 0);
    chk("R3 dst overflow bit6", 32'(status), 32'h040);

    // R5 source thresholds lo=2 hi=4
    wr(3'd5, 32'h7FF);
    wr(3'd2, (32'd2 << 16) | 32'd4);
    wr(3'd0, 32'd4);
    idle(1);
    chk("R5 src level", 32'(src_level), 5);
    chk("R5 src high bit1", 32'(status[2:1]), 32'b01);
    pulse_src(4);
    idle(1);
    chk("R5 src level low", 32'(src_level), 1);
    chk("R5 src low bit2", 32'(status[2:1]), 32'b11);
    pulse_src(1);

    // R5 destination thresholds lo=1 hi=1
    wr(3'd5, 32'h7FF);
    wr(3'd3, (32'd1 << 16) | 32'd1);
    wr(3'd1, 32'd2);
    idle(1);
    chk("R5 dst high bit3", 32'(status[4:3]), 32'b01);
    pulse_dst(2);
    idle(1);
    chk("R5 dst rd", 32'(dst_rd_idx), 2);
    chk("R5 dst low bit4", 32'(status[4:3]), 32'b11);

    // R6 error pulses
    wr(3'd5, 32'h7FF);
    @(negedge clk); err_in = 4'b1010;
    @(negedge clk); err_in = 4'b0000;
    chk("R6 error bits", 32'(status), 32'h500);

    // R7 set and clear in same cycle on bit7
    wr(3'd5, 32'h7FF);
    @(negedge clk); err_in = 4'b0001; cfg_we = 1'b1; cfg_addr = 3'd5; cfg_wdata = 32'h080;
    @(negedge clk); err_in = 4'b0000; cfg_we = 1'b0;
    chk("R7 set wins", 32'(status[7]), 1);
    wr(3'd5, 32'h080);
    chk("R7 clear bit7", 32'(status[7]), 0);

    // R8 interrupt enable
    pulse_dst(1);
    chk("R8 masked irq", 32'(irq), 0);
    wr(3'd4, 32'h040);
    chk("R8 enabled irq", 32'(irq), 1);
    wr(3'd4, 32'h020);
    chk("R8 other enable", 32'(irq), 0);
    wr(3'd4, 32'h000);

    // R9 halt handshake (src rd=4, wr=4)
    wr(3'd0, 32'd7);
    xfer_busy = 1'b1;
    wr(3'd6, 32'd1);
    idle(2);
    chk("R9 wait busy", 32'(halted), 0);
    xfer_busy = 1'b0;
    idle(1);
    chk("R9 halted", 32'(halted), 1);
    pulse_src(2);
    chk("R9 frozen rd", 32'(src_rd_idx), 4);
    chk("R9 frozen level", 32'(src_level), 3);
    wr(3'd6, 32'd0);
    idle(1);
    chk("R9 released", 32'(halted), 0);
    pulse_src(1);
    chk("R9 resume rd", 32'(src_rd_idx), 5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule